// File: doc/BRIEF.md
# Multichannel ADC Parallel Capture Controller

This block sits on the host side of a simultaneous-sampling converter that has up to four inputs and a 10-bit parallel output bus. It divides the system clock into a free-running conversion clock. Around the falling edge of that clock it drives a chip-select pair and a read line, so that each conversion period yields exactly one bus read. The converter's pipeline makes the first words after start-up stale. The block drops them, then gives every later word a channel number and sends it out on a simple valid/channel/data stream.

In multichannel operation the converter pulls a frame marker low while the first channel's word is on the bus. The remaining channels follow in ascending order. The block locks onto that marker and counts channels from it. It flags a sync error when the marker comes too early, or when it fails to come after a full frame of words. In single-channel operation the marker carries no meaning, so the block ignores it and tags every word as the first channel.

Top module: `adc_cap_ctrl`

## Requirements
- R1: With H = max(cfg_half, 2), the conversion clock has a period of 2H system cycles. Phase 0 is the first cycle after reset is released internally. In phases 0..H-1 the clock is high and in phases H..2H-1 it is low.
- R2: The read line adc_rd_n is low only in phases H+1..2H-1. The select adc_cs0_n is low in phases H..2H-1. The select adc_cs1 is held high. Because of these windows, read is high in the cycle of each falling edge and in the cycle before it.
- R3: The bus word and marker are sampled in phase 2H-1, the last read cycle. A word that is emitted appears on out_data in the next cycle, phase 0, with out_valid high for that one cycle only.
- R4: The first four words captured after reset are discarded. They produce neither out_valid nor sync_err.
- R5: When cfg_chans = 0 (one channel), every word after the discard is emitted with out_chan = 0 (first channel). adc_sync_n has no effect and sync_err stays low.
- R6: When cfg_chans = N-1 with N > 1, a word captured with adc_sync_n low is emitted as out_chan = 0. Each later word without the marker is emitted with the previous channel plus one. out_chan k means input channel k+1.
- R7: In multichannel mode, words captured before the block has seen its first marker are dropped without an error. The same holds after a missing-marker error.
- R8: If the block is locked and N words have passed since the last marker, a following word without the marker is a missing-marker error. sync_err pulses in that word's output slot (phase 0), the word is dropped and the block stops tracking until the next marker.
- R9: A marker that arrives while the expected next channel is not 0 is an early-marker error. sync_err pulses in that word's slot, the word is still emitted as out_chan = 0 and counting restarts from it.
- R10: While rst_n is low, and for the two cycles after it rises, the outputs are adc_conv_clk = 1, adc_rd_n = 1, adc_cs0_n = 1, out_valid = 0 and sync_err = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_chans | input | 2 | Channel count minus one; change only during reset |
| cfg_half | input | 6 | Conversion clock half period in system cycles (values below 2 act as 2) |
| adc_conv_clk | output | 1 | Free-running conversion clock to the converter |
| adc_cs0_n | output | 1 | Active-low chip select |
| adc_cs1 | output | 1 | Active-high chip select, held high |
| adc_rd_n | output | 1 | Active-low read strobe |
| adc_data | input | 10 | Converter parallel data bus |
| adc_sync_n | input | 1 | Active-low frame marker, low with the first channel's word |
| out_valid | output | 1 | One-cycle pulse per emitted word |
| out_chan | output | 2 | Channel index of the emitted word (0 = first channel) |
| out_data | output | 10 | Emitted sample |
| sync_err | output | 1 | One-cycle pulse on an early or missing frame marker |

## Verification
A phase counter that is out of step moves the edge of the conversion clock or the read window. That shows at the strobe pins in the very cycle it goes wrong. A wrong channel counter or lock state shows up at the output in the next emission slot, one conversion period later, as a wrong out_chan, a dropped word or a spurious or missing sync_err. A discard count that is off by one shows as out_valid appearing or vanishing on the fourth or fifth word after reset. The stimulus places a missing marker and an early marker late in each multichannel run, so the hunt and relock paths are both reached after the block has locked.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int ADC_DATA_W = 10;
  localparam int ADC_CH_W   = 2;
  localparam int ADC_DIV_W  = 6;
  localparam int ADC_SKIP   = 4;

  typedef enum logic {
    TRK_HUNT,
    TRK_LOCK
  } trk_state_t;
endpackage

// File: rtl/adc_cap_rst_sync.sv
module adc_cap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_int_n = hold_q;
endmodule

// File: rtl/adc_cap_timing.sv
module adc_cap_timing #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_half,
  output logic             conv_clk,
  output logic             cs0_n,
  output logic             rd_n,
  output logic             cap_stb
);
  localparam int CNT_W = DIV_W + 1;
  localparam logic [CNT_W-1:0] MIN_HALF = CNT_W'(2);

  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             wrap;
  logic             conv_d;
  logic             cs0_d;
  logic             rd_d;

  always_comb begin
    half    = ({1'b0, cfg_half} < MIN_HALF) ? MIN_HALF : {1'b0, cfg_half};
    last    = (half << 1) - CNT_W'(1);
    wrap    = (cnt_q >= last);
    cap_stb = (cnt_q == last);
    cnt_d   = wrap ? '0 : cnt_q + CNT_W'(1);
    conv_d  = (cnt_d < half);
    cs0_d   = ~(cnt_d >= half);
    rd_d    = ~(cnt_d > half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      conv_clk <= 1'b1;
      cs0_n    <= 1'b1;
      rd_n     <= 1'b1;
    end else begin
      cnt_q    <= cnt_d;
      conv_clk <= conv_d;
      cs0_n    <= cs0_d;
      rd_n     <= rd_d;
    end
  end
endmodule

// File: rtl/adc_cap_tagger.sv
module adc_cap_tagger
  import adc_cap_pkg::*;
#(
  parameter int DATA_W = ADC_DATA_W,
  parameter int CH_W   = ADC_CH_W,
  parameter int SKIP   = ADC_SKIP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_stb,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_sync_n,
  input  logic [CH_W-1:0]   cfg_chans,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_chan,
  output logic [DATA_W-1:0] out_data,
  output logic              sync_err
);
  localparam int SKIP_W = $clog2(SKIP + 1);

  trk_state_t        st_q, st_d;
  logic [SKIP_W-1:0] skip_q, skip_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic [CH_W-1:0]   chan_inc;
  logic [CH_W-1:0]   tag_chan;
  logic              warm;
  logic              marker;
  logic              emit;
  logic              fault;

  always_comb begin
    skip_d   = skip_q;
    st_d     = st_q;
    chan_d   = chan_q;
    emit     = 1'b0;
    fault    = 1'b0;
    tag_chan = '0;
    warm     = (skip_q == SKIP_W'(SKIP));
    marker   = ~bus_sync_n;
    chan_inc = (chan_q == cfg_chans) ? '0 : chan_q + 1'b1;
    if (cap_stb) begin
      if (!warm) begin
        skip_d = skip_q + 1'b1;
      end else if (cfg_chans == '0) begin
        emit = 1'b1;
      end else if (marker) begin
        emit   = 1'b1;
        chan_d = '0;
        st_d   = TRK_LOCK;
        fault  = (st_q == TRK_LOCK) && (chan_inc != '0);
      end else if (st_q == TRK_LOCK) begin
        if (chan_inc == '0) begin
          fault = 1'b1;
          st_d  = TRK_HUNT;
        end else begin
          emit     = 1'b1;
          tag_chan = chan_inc;
          chan_d   = chan_inc;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= TRK_HUNT;
      skip_q    <= '0;
      chan_q    <= '0;
      out_valid <= 1'b0;
      sync_err  <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else begin
      st_q      <= st_d;
      skip_q    <= skip_d;
      chan_q    <= chan_d;
      out_valid <= emit;
      sync_err  <= fault;
      if (emit) begin
        out_chan <= tag_chan;
        out_data <= bus_data;
      end
    end
  end
endmodule

// File: rtl/adc_cap_ctrl.sv
module adc_cap_ctrl
  import adc_cap_pkg::*;
#(
  parameter int DATA_W = ADC_DATA_W,
  parameter int CH_W   = ADC_CH_W,
  parameter int DIV_W  = ADC_DIV_W,
  parameter int SKIP   = ADC_SKIP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_W-1:0]   cfg_chans,
  input  logic [DIV_W-1:0]  cfg_half,
  output logic              adc_conv_clk,
  output logic              adc_cs0_n,
  output logic              adc_cs1,
  output logic              adc_rd_n,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_sync_n,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_chan,
  output logic [DATA_W-1:0] out_data,
  output logic              sync_err
);
  logic rst_int_n;
  logic cap_stb;

  adc_cap_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  adc_cap_timing #(.DIV_W(DIV_W)) u_timing (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cfg_half (cfg_half),
    .conv_clk (adc_conv_clk),
    .cs0_n    (adc_cs0_n),
    .rd_n     (adc_rd_n),
    .cap_stb  (cap_stb)
  );

  adc_cap_tagger #(.DATA_W(DATA_W), .CH_W(CH_W), .SKIP(SKIP)) u_tagger (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cap_stb    (cap_stb),
    .bus_data   (adc_data),
    .bus_sync_n (adc_sync_n),
    .cfg_chans  (cfg_chans),
    .out_valid  (out_valid),
    .out_chan   (out_chan),
    .out_data   (out_data),
    .sync_err   (sync_err)
  );

  assign adc_cs1 = 1'b1;
endmodule

// File: rtl/adc_cap_ctrl_chk.sv
module adc_cap_ctrl_chk #(
  parameter int CH_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CH_W-1:0] cfg_chans,
  input logic            adc_conv_clk,
  input logic            adc_cs0_n,
  input logic            adc_cs1,
  input logic            adc_rd_n,
  input logic            out_valid,
  input logic [CH_W-1:0] out_chan,
  input logic            sync_err
);
  logic [CH_W-1:0] seen_chan_q;
  logic            seen_any_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_chan_q <= '0;
      seen_any_q  <= 1'b0;
    end else if (out_valid) begin
      seen_chan_q <= out_chan;
      seen_any_q  <= 1'b1;
    end
  end

  // R2
  rd_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n |-> (!adc_cs0_n && adc_cs1));

  // R2
  rd_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n |-> !adc_conv_clk);

  // R2
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_conv_clk) |-> (adc_rd_n && $past(adc_rd_n)));

  // R3
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(!adc_rd_n) && adc_rd_n));

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5
  single_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chans == '0) |-> (!sync_err && (!out_valid || out_chan == '0)));

  // R6
  chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_chan != '0) |->
      (seen_any_q && out_chan == CH_W'(seen_chan_q + 1'b1) && out_chan <= cfg_chans));

  // R8
  err_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> $past(!adc_rd_n));
endmodule

bind adc_cap_ctrl adc_cap_ctrl_chk #(.CH_W(CH_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_chans    (cfg_chans),
  .adc_conv_clk (adc_conv_clk),
  .adc_cs0_n    (adc_cs0_n),
  .adc_cs1      (adc_cs1),
  .adc_rd_n     (adc_rd_n),
  .out_valid    (out_valid),
  .out_chan     (out_chan),
  .sync_err     (sync_err)
);

// File: tb/adc_cap_ctrl_test.sv
`timescale 1ns/1ps
module adc_cap_ctrl_test;
  logic       clk;
  logic       rst_n;
  logic [1:0] cfg_chans;
  logic [5:0] cfg_half;
  logic       adc_conv_clk, adc_cs0_n, adc_cs1, adc_rd_n;
  logic [9:0] adc_data;
  logic       adc_sync_n;
  logic       out_valid;
  logic [1:0] out_chan;
  logic [9:0] out_data;
  logic       sync_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // converter model state
  int adc_n = 1;
  int ak = 0;
  int ac = 0;
  bit miss_done, early_done;

  // reference model state
  int  p, h, n, j, last_c;
  bit  locked, have_cap;
  logic [9:0] cap_d;
  logic       cap_s;

  adc_cap_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_chans(cfg_chans), .cfg_half(cfg_half),
    .adc_conv_clk(adc_conv_clk), .adc_cs0_n(adc_cs0_n), .adc_cs1(adc_cs1),
    .adc_rd_n(adc_rd_n), .adc_data(adc_data), .adc_sync_n(adc_sync_n),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data),
    .sync_err(sync_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "R3", "watchdog cycles", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Converter: a new word after every falling edge of the conversion clock
  always @(negedge adc_conv_clk) begin
    #1;
    if (adc_n == 1) begin
      adc_sync_n = (ak % 3 == 1);
    end else begin
      if (!early_done && ak >= 33 && ac != 0) begin
        ac = 0;
        early_done = 1'b1;
      end
      adc_sync_n = (ac != 0);
      if (ac == 0 && !miss_done && ak >= 20) begin
        adc_sync_n = 1'b1;
        miss_done = 1'b1;
      end
    end
    adc_data = 10'((ak * 53 + ac * 7 + 5) % 1024);
    ac = (ac + 1) % adc_n;
    ak++;
  end

  task automatic model(input logic s_n, output bit ev, output int ec,
                       output bit ee, output string tag);
    int nxt;
    ev = 1'b0; ec = 0; ee = 1'b0; tag = "R3";
    if (j < 4) begin
      tag = "R4";
      j++;
      return;
    end
    if (n == 1) begin
      ev = 1'b1; tag = "R5";
      return;
    end
    nxt = (last_c + 1) % n;
    if (!locked) begin
      if (!s_n) begin
        ev = 1'b1; locked = 1'b1; last_c = 0; tag = "R6";
      end else begin
        tag = "R7";
      end
    end else if (!s_n) begin
      ev = 1'b1; ee = (nxt != 0); last_c = 0;
      tag = ee ? "R9" : "R6";
    end else if (nxt == 0) begin
      ee = 1'b1; locked = 1'b0; tag = "R8";
    end else begin
      ev = 1'b1; ec = nxt; last_c = nxt; tag = "R6";
    end
  endtask

  task automatic check_reset_outputs();
    chk(adc_conv_clk == 1'b1, "R10", "conv_clk in reset", int'(adc_conv_clk), 1);
    chk(adc_rd_n == 1'b1, "R10", "rd_n in reset", int'(adc_rd_n), 1);
    chk(adc_cs0_n == 1'b1, "R10", "cs0_n in reset", int'(adc_cs0_n), 1);
    chk(out_valid == 1'b0, "R10", "valid in reset", int'(out_valid), 0);
    chk(sync_err == 1'b0, "R10", "sync_err in reset", int'(sync_err), 0);
  endtask

  task automatic step();
    bit    ev, ee;
    int    ec;
    string tag;
    p = (p == 2 * h - 1) ? 0 : p + 1;
    chk(adc_conv_clk == (p < h), "R1", "conv_clk", int'(adc_conv_clk), int'(p < h));
    chk(adc_rd_n == !(p > h), "R2", "rd_n", int'(adc_rd_n), int'(!(p > h)));
    chk(adc_cs0_n == !(p >= h), "R2", "cs0_n", int'(adc_cs0_n), int'(!(p >= h)));
    chk(adc_cs1 == 1'b1, "R2", "cs1", int'(adc_cs1), 1);
    ev = 1'b0; ee = 1'b0; ec = 0; tag = "R3";
    if (p == 0 && have_cap) begin
      model(cap_s, ev, ec, ee, tag);
      have_cap = 1'b0;
    end
    chk(out_valid == ev, tag, "out_valid", int'(out_valid), int'(ev));
    chk(sync_err == ee, tag, "sync_err", int'(sync_err), int'(ee));
    if (ev && out_valid) begin
      chk(int'(out_chan) == ec, tag, "out_chan", int'(out_chan), ec);
      chk(out_data == cap_d, "R3", "out_data", int'(out_data), int'(cap_d));
    end
    if (p == 2 * h - 1) begin
      cap_d = adc_data;
      cap_s = adc_sync_n;
      have_cap = 1'b1;
    end
  endtask

  task automatic run_case(input int chans, input int half_cfg, input int words);
    rst_n = 1'b0;
    cfg_chans = 2'(chans - 1);
    cfg_half = 6'(half_cfg);
    repeat (3) @(negedge clk);
    n = chans;
    h = (half_cfg < 2) ? 2 : half_cfg;
    adc_n = chans;
    ak = 0;
    ac = 1 % chans;
    miss_done = 1'b0;
    early_done = 1'b0;
    j = 0; last_c = 0; locked = 1'b0; have_cap = 1'b0; p = 0;
    check_reset_outputs();
    rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check_reset_outputs();
    end
    repeat (words * 2 * h) begin
      @(negedge clk);
      step();
    end
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_chans = 2'd0;
    cfg_half = 6'd2;
    adc_data = 10'd0;
    adc_sync_n = 1'b1;
    run_case(1, 2, 80);   // R5 single channel, marker toggling
    run_case(2, 3, 80);   // R6 R7 R8 R9
    run_case(4, 2, 80);   // R6 R7 R8 R9
    run_case(3, 5, 80);   // R1 longer half period
    run_case(2, 0, 60);   // R1 half period clamp to 2
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule